// File: doc/BRIEF.md
# Field extract and rotate unit

A purely combinational 16-bit cycler-masker steered by a dense 8-bit function code. Most of the code space encodes every legal field extraction: the code picks a field by its left bit position and its width. Bit 0 is the most significant bit. The selected field comes out right-justified with zeros above it. A second range of codes extracts a narrow field of up to four bits. That value also appears on a separate dispatch output, so it can be loaded as the low bits of a multi-way branch target.

The remaining codes shift the operand left with zero fill, rotate it left, keep only its upper byte, or produce zero. Right shifts, right rotates and the low-byte mask have no codes of their own. They are reached through the extract range or the rotate range, as shown in the requirements below. Codes past the end of the map are flagged illegal. The block sits between a register read port and the result bus. Upstream logic computes the codes.

Top module: `fxr_unit`

## Requirements
- R1: For field width s (1 to 15) and left position p with p + s <= 16, code base(s) + p returns operand bits p..p+s-1 (bit 0 = MSB), right-justified, with all higher result bits zero.
- R2: base(1) = 0 and base(s+1) = base(s) + 17 - s. This gives bases 0, 16, 31, 45, 58, 70, 81, 91, 100, 108, 115, 121, 126, 130, 133 and fills codes 0 to 134 with no gaps.
- R3: For dispatch width d (1 to 4) and position p with p + d <= 16, code dbase(d) + p is decoded as follows. The dispatch bases are 135, 151, 166 and 180, covering codes 135 to 192. The result carries the right-justified field, the 4-bit dispatch output carries the same value, and dispatch-valid is 1.
- R4: Dispatch-valid is 0 and the dispatch output is 0 for every code outside 135 to 192.
- R5: Codes 193 to 207 return the operand shifted left by (code - 192) bits, with zero fill.
- R6: Codes 208 to 222 return the operand rotated left by (code - 207) bits. A right rotate by n equals the left rotate by 16 - n.
- R7: Code 223 returns the operand AND 0xFF00.
- R8: Code 224 returns zero.
- R9: Codes 225 to 255 set the illegal flag and return zero on the result and dispatch outputs. The illegal flag is 0 for codes 0 to 224.
- R10: A right shift by n (1 to 15) is obtained from the extract code with position 0 and width 16 - n, and equals operand >> n.
- R11: The low-byte mask is code 99 (position 8, width 8) and equals operand AND 0x00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 16 | Word to be cycled or masked; bit 0 is the leftmost bit |
| func_code_i | input | 8 | Function code selecting extract, dispatch, shift, rotate or mask |
| result_o | output | 16 | Computed word |
| disp_o | output | 4 | Extracted dispatch field, zero unless a dispatch code is applied |
| disp_valid_o | output | 1 | High while a dispatch code is applied |
| illegal_o | output | 1 | High for codes beyond the defined map |

## Verification
The hardest cases to reach are the edges where one range ends and the next begins. Examples are the last position of each width, code 134 next to the first dispatch code, and 192 next to the first shift. Off-by-one errors in the range bounds only show up when such a code is applied to an operand whose bits differ around the field edge. The bench therefore walks every code of every range. It computes each expected code from a running count of positions per width. Each code is applied to several random operands and to an alternating-bit word. The shift and rotate counts are checked at both ends, 1 and 15.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    localparam int FIDX_W = 6;

    typedef enum logic [2:0] {
        OP_FIELD  = 3'd0,
        OP_DISP   = 3'd1,
        OP_SHL    = 3'd2,
        OP_ROTL   = 3'd3,
        OP_HIMASK = 3'd4,
        OP_ZERO   = 3'd5,
        OP_BAD    = 3'd6
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [FIDX_W-1:0]   pos;
        logic [FIDX_W-1:0]   size;
        logic [FIDX_W-1:0]   amt;
    } decode_t;

    // first code of the run of width s; width k has w+1-k positions
    function automatic int run_base(input int w, input int s);
        int acc;
        acc = 0;
        for (int k = 1; k < s; k++) acc += w + 1 - k;
        return acc;
    endfunction

    function automatic int field_codes(input int w);
        return run_base(w, w);
    endfunction

    function automatic int disp_codes(input int w, input int dmax);
        return run_base(w, dmax + 1);
    endfunction

endpackage

// File: rtl/fxr_decode.sv
module fxr_decode
    import fxr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 8,
    parameter int DISP_MAX = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output decode_t           dec_o
);
    localparam int FIELD_END = field_codes(DATA_W);
    localparam int DISP_END  = FIELD_END + disp_codes(DATA_W, DISP_MAX);
    localparam int SHL_LO    = DISP_END;
    localparam int ROT_LO    = SHL_LO + DATA_W - 1;
    localparam int HI_CODE   = ROT_LO + DATA_W - 1;
    localparam int ZERO_CODE = HI_CODE + 1;

    always_comb begin
        int c;
        c = int'(code_i);
        dec_o = '{kind: OP_BAD, pos: '0, size: '0, amt: '0};
        if (c < FIELD_END) begin
            for (int s = 1; s < DATA_W; s++) begin
                if (c >= run_base(DATA_W, s) &&
                    c <  run_base(DATA_W, s) + DATA_W + 1 - s) begin
                    dec_o.kind = OP_FIELD;
                    dec_o.size = FIDX_W'(s);
                    dec_o.pos  = FIDX_W'(c - run_base(DATA_W, s));
                end
            end
        end else if (c < DISP_END) begin
            for (int d = 1; d <= DISP_MAX; d++) begin
                if (c >= FIELD_END + run_base(DATA_W, d) &&
                    c <  FIELD_END + run_base(DATA_W, d) + DATA_W + 1 - d) begin
                    dec_o.kind = OP_DISP;
                    dec_o.size = FIDX_W'(d);
                    dec_o.pos  = FIDX_W'(c - FIELD_END - run_base(DATA_W, d));
                end
            end
        end else if (c < ROT_LO) begin
            dec_o.kind = OP_SHL;
            dec_o.amt  = FIDX_W'(c - SHL_LO + 1);
        end else if (c < HI_CODE) begin
            dec_o.kind = OP_ROTL;
            dec_o.amt  = FIDX_W'(c - ROT_LO + 1);
        end else if (c == HI_CODE) begin
            dec_o.kind = OP_HIMASK;
        end else if (c == ZERO_CODE) begin
            dec_o.kind = OP_ZERO;
        end
    end

    // R1 / R3: every decoded field lies inside the word
    always_comb begin
        if (!$isunknown(code_i) && (dec_o.kind == OP_FIELD || dec_o.kind == OP_DISP)) begin
            a_r1_field_inside: assert (int'(dec_o.pos) + int'(dec_o.size) <= DATA_W &&
                                       dec_o.size != '0)
                else $error("field outside word");
        end
        if (!$isunknown(code_i) && dec_o.kind == OP_DISP) begin
            a_r3_disp_narrow: assert (int'(dec_o.size) <= DISP_MAX)
                else $error("dispatch field too wide");
        end
    end

endmodule

// File: rtl/fxr_field.sv
module fxr_field
    import fxr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [FIDX_W-1:0] pos_i,
    input  logic [FIDX_W-1:0] size_i,
    output logic [DATA_W-1:0] y_o
);
    logic [DATA_W:0]   one_w;
    logic [DATA_W:0]   mask_w;
    logic [DATA_W-1:0] aligned;
    int                drop;

    always_comb begin
        one_w   = {{DATA_W{1'b0}}, 1'b1};
        mask_w  = (one_w << size_i) - one_w;
        drop    = DATA_W - int'(pos_i) - int'(size_i);
        if (drop < 0) drop = 0;
        aligned = x_i >> drop;
        y_o     = aligned & mask_w[DATA_W-1:0];
    end

    // R1: nothing survives above the field width
    always_comb begin
        if (!$isunknown({x_i, pos_i, size_i}) && int'(size_i) < DATA_W) begin
            a_r1_upper_zero: assert ((y_o >> size_i) == '0)
                else $error("bits above field width");
        end
    end

endmodule

// File: rtl/fxr_shift.sv
module fxr_shift
    import fxr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter bit ROTATE = 1'b0
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [FIDX_W-1:0] amt_i,
    output logic [DATA_W-1:0] y_o
);
    generate
        if (ROTATE) begin : g_rot
            always_comb begin
                if (int'(amt_i) == 0 || int'(amt_i) >= DATA_W) y_o = x_i;
                else y_o = (x_i << amt_i) | (x_i >> (DATA_W - int'(amt_i)));
            end
            // R6: a rotation keeps the number of ones
            always_comb begin
                if (!$isunknown({x_i, amt_i})) begin
                    a_r6_rot_popcount: assert ($countones(y_o) == $countones(x_i))
                        else $error("rotate lost bits");
                end
            end
        end else begin : g_shl
            always_comb y_o = x_i << amt_i;
            // R5: vacated low bits are zero
            always_comb begin
                if (!$isunknown({x_i, amt_i}) && int'(amt_i) < DATA_W) begin
                    a_r5_zero_fill: assert ((y_o & ~({DATA_W{1'b1}} << amt_i)) == '0)
                        else $error("shift did not zero fill");
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fxr_unit.sv
module fxr_unit
    import fxr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 8,
    parameter int DISP_MAX = 4
) (
    input  logic [DATA_W-1:0]   operand_i,
    input  logic [CODE_W-1:0]   func_code_i,
    output logic [DATA_W-1:0]   result_o,
    output logic [DISP_MAX-1:0] disp_o,
    output logic                disp_valid_o,
    output logic                illegal_o
);
    localparam logic [DATA_W-1:0] HI_MASK = {DATA_W{1'b1}} << (DATA_W - DATA_W / 2);

    decode_t           dec;
    logic [DATA_W-1:0] field_y;
    logic [DATA_W-1:0] sh_y [2];

    fxr_decode #(.DATA_W(DATA_W), .CODE_W(CODE_W), .DISP_MAX(DISP_MAX)) u_dec (
        .code_i (func_code_i),
        .dec_o  (dec)
    );

    fxr_field #(.DATA_W(DATA_W)) u_field (
        .x_i    (operand_i),
        .pos_i  (dec.pos),
        .size_i (dec.size),
        .y_o    (field_y)
    );

    // index 0: left shift, index 1: left rotate
    for (genvar g = 0; g < 2; g++) begin : g_sh
        fxr_shift #(.DATA_W(DATA_W), .ROTATE(g == 1)) u_sh (
            .x_i   (operand_i),
            .amt_i (dec.amt),
            .y_o   (sh_y[g])
        );
    end

    always_comb begin
        result_o     = '0;
        disp_o       = '0;
        disp_valid_o = 1'b0;
        illegal_o    = 1'b0;
        unique case (dec.kind)
            OP_FIELD:  result_o = field_y;
            OP_DISP: begin
                result_o     = field_y;
                disp_o       = field_y[DISP_MAX-1:0];
                disp_valid_o = 1'b1;
            end
            OP_SHL:    result_o = sh_y[0];
            OP_ROTL:   result_o = sh_y[1];
            OP_HIMASK: result_o = operand_i & HI_MASK;
            OP_ZERO:   result_o = '0;
            default:   illegal_o = 1'b1;
        endcase
    end

    always_comb begin
        if (!$isunknown({operand_i, func_code_i})) begin
            a_r9_illegal_quiet: assert (!illegal_o || (result_o == '0 && disp_o == '0 && !disp_valid_o))
                else $error("illegal code produced data");
            a_r3_disp_matches: assert (!disp_valid_o ||
                                       result_o == {{(DATA_W-DISP_MAX){1'b0}}, disp_o})
                else $error("dispatch output differs from result");
            a_r4_disp_idle: assert (disp_valid_o || disp_o == '0)
                else $error("dispatch value without valid");
            a_r7_himask_low: assert (dec.kind != OP_HIMASK || (result_o & ~HI_MASK) == '0)
                else $error("low half leaked through mask");
        end
    end

endmodule

// File: tb/tb_fxr_unit.sv
module tb_fxr_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic [15:0] operand;
    logic [7:0]  code;
    logic [15:0] result;
    logic [3:0]  disp;
    logic        disp_valid;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    fxr_unit dut (
        .operand_i    (operand),
        .func_code_i  (code),
        .result_o     (result),
        .disp_o       (disp),
        .disp_valid_o (disp_valid),
        .illegal_o    (illegal)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural field pick: bit 0 is the leftmost bit
    function automatic logic [15:0] pick(input logic [15:0] x, input int p, input int s);
        logic [15:0] e;
        e = '0;
        for (int i = 0; i < s; i++) e[s-1-i] = x[15-p-i];
        return e;
    endfunction

    function automatic logic [15:0] rotl(input logic [15:0] x, input int n);
        logic [15:0] r;
        r = x;
        for (int i = 0; i < n; i++) r = {r[14:0], r[15]};
        return r;
    endfunction

    task automatic apply(input logic [7:0] c, input logic [15:0] x,
                         input logic [15:0] e_res, input logic [3:0] e_disp,
                         input logic e_dv, input logic e_ill, input string tag);
        @(posedge clk);
        #1;
        code    = c;
        operand = x;
        @(negedge clk);
        n_checks++;
        if (result !== e_res || disp !== e_disp || disp_valid !== e_dv || illegal !== e_ill) begin
            n_fail++;
            $display("FAIL %s code=%0d op=%h: got res=%h disp=%h dv=%b ill=%b, expected res=%h disp=%h dv=%b ill=%b",
                     tag, c, x, result, disp, disp_valid, illegal, e_res, e_disp, e_dv, e_ill);
        end
    endtask

    task automatic operands(output logic [15:0] ops [5]);
        ops[0] = 16'hA5C3;
        ops[1] = 16'h5555;
        ops[2] = 16'($urandom);
        ops[3] = 16'($urandom);
        ops[4] = 16'($urandom);
    endtask

    initial begin
        logic [15:0] ops [5];
        int b;
        code    = 8'd224;
        operand = 16'hFFFF;
        // initial state: zero code on all-ones operand
        apply(8'd224, 16'hFFFF, 16'h0000, 4'h0, 1'b0, 1'b0, "R8 initial zero");

        // R1, R2: every width and position, code from running base
        b = 0;
        for (int s = 1; s <= 15; s++) begin
            for (int p = 0; p + s <= 16; p++) begin
                operands(ops);
                for (int k = 0; k < 5; k++)
                    apply(8'(b + p), ops[k], pick(ops[k], p, s), 4'h0, 1'b0, 1'b0, "R1 R2 field extract");
            end
            b += 17 - s;
        end

        // R3: dispatch widths 1..4
        for (int d = 1; d <= 4; d++) begin
            for (int p = 0; p + d <= 16; p++) begin
                operands(ops);
                for (int k = 0; k < 5; k++)
                    apply(8'(b + p), ops[k], pick(ops[k], p, d), 4'(pick(ops[k], p, d)),
                          1'b1, 1'b0, "R3 dispatch field");
            end
            b += 17 - d;
        end

        // R5: left shifts 1..15
        for (int n = 1; n <= 15; n++) begin
            operands(ops);
            for (int k = 0; k < 5; k++)
                apply(8'(192 + n), ops[k], ops[k] << n, 4'h0, 1'b0, 1'b0, "R5 left shift");
        end

        // R6: left rotates, and right rotate via 16-n
        for (int n = 1; n <= 15; n++) begin
            operands(ops);
            for (int k = 0; k < 5; k++)
                apply(8'(207 + n), ops[k], rotl(ops[k], n), 4'h0, 1'b0, 1'b0, "R6 left rotate");
            apply(8'(207 + 16 - n), 16'h8001, (16'h8001 >> n) | (16'h8001 << (16 - n)),
                  4'h0, 1'b0, 1'b0, "R6 right rotate");
        end

        // R7, R8
        operands(ops);
        for (int k = 0; k < 5; k++) begin
            apply(8'd223, ops[k], ops[k] & 16'hFF00, 4'h0, 1'b0, 1'b0, "R7 upper mask");
            apply(8'd224, ops[k], 16'h0000, 4'h0, 1'b0, 1'b0, "R8 zero");
        end

        // R9 and R4: illegal codes
        for (int c = 225; c <= 255; c++)
            apply(8'(c), 16'hFFFF, 16'h0000, 4'h0, 1'b0, 1'b1, "R9 R4 illegal code");

        // R10: right shift via position 0, width 16-n
        for (int n = 1; n <= 15; n++) begin
            int base_s;
            base_s = 0;
            for (int k = 1; k < 16 - n; k++) base_s += 17 - k;
            apply(8'(base_s), 16'hBEEF, 16'hBEEF >> n, 4'h0, 1'b0, 1'b0, "R10 right shift");
        end

        // R11: low-byte mask
        apply(8'd99, 16'h1234, 16'h0034, 4'h0, 1'b0, 1'b0, "R11 low byte mask");
        apply(8'd99, 16'hFFFF, 16'h00FF, 4'h0, 1'b0, 1'b0, "R11 low byte mask");

        // boundaries around range edges
        apply(8'd134, 16'h7FFF, 16'h7FFF, 4'h0, 1'b0, 1'b0, "R2 last extract code");
        apply(8'd135, 16'h8000, 16'h0001, 4'h1, 1'b1, 1'b0, "R3 first dispatch code");
        apply(8'd192, 16'h000F, 16'h000F, 4'hF, 1'b1, 1'b0, "R3 last dispatch code");
        apply(8'd193, 16'h8001, 16'h0002, 4'h0, 1'b0, 1'b0, "R4 R5 first shift code");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule